// File: doc/BRIEF.md
# Delimiter or Length Packet Framer

The framer sits behind a serial receiver and turns its stream of received words (up to 9 bits each, one per `in_valid` strobe) into packets. Each accepted word is written into a packet buffer first and only then tested. The open packet closes when that word equals the programmed delimiter, when the number of stored words reaches the programmed length, or when the buffer is full, whichever comes first. A delimiter that closes a packet stays in the packet as its final word.

A closed packet drains on a valid/ready stream. `out_last` marks the final word. Each word carries the time at which the packet's first word was taken and the time at which its closing word was taken. While a packet drains, the input is held off with `in_ready` low. The next accepted word starts a fresh packet.

The delimiter setting is one bit wider than a word, and setting that top bit turns delimiter matching off. A length of zero turns length counting off. With both turned off, words are still accepted but are thrown away, and no packets are formed.

Top module: `pkt_framer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With delimiter matching on (`cfg_delim[9]`=0), a word equal to `cfg_delim[8:0]` closes the packet and is presented as its final word, with `out_last`=1.
- R3: With `cfg_len`=N (N≥1), a packet with no earlier delimiter closes on its N-th word.
- R4: When both conditions are enabled, the packet closes on whichever condition is met first.
- R5: With `cfg_delim[9]`=1 and `cfg_len`=0, accepted words are discarded and `out_valid` stays 0.
- R6: `cfg_delim[9]`=1 disables delimiter matching even for words whose low bits equal `cfg_delim[8:0]`, and `cfg_len`=0 disables the length limit.
- R7: `out_start_time` equals the `time_now` value sampled with the packet's first accepted word. `out_end_time` equals the value sampled with its closing word. Both are held for every word of the packet.
- R8: If DEPTH words are stored and neither condition was met by the last of them, the packet is force-closed with `out_ovf`=1. In every other case `out_ovf`=0, including when the length condition or a delimiter coincides with the DEPTH-th word.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_last` hold. `out_last` is 1 only on the packet's final word.
- R10: `in_ready` is 0 whenever a packet is draining. After the final word's handshake, the next accepted word begins a new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word strobe |
| in_ready | output | 1 | Framer can take a word |
| in_data | input | 9 | Received word |
| time_now | input | 16 | Free-running time stamp source |
| cfg_delim | input | 10 | Delimiter value; bit 9 set disables matching |
| cfg_len | input | 8 | Packet length in words; 0 disables |
| out_valid | output | 1 | Packet word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 9 | Packet word |
| out_last | output | 1 | Final word of the packet |
| out_ovf | output | 1 | Packet was force-closed by a full buffer |
| out_start_time | output | 16 | Time of the packet's first word |
| out_end_time | output | 16 | Time of the packet's closing word |

## Verification
The assertions assume that `cfg_delim` and `cfg_len` change only while no packet is open, so that a grouping mode cannot be switched off in the middle of a packet. The stimulus keeps to this rule. It changes the configuration only after the bench's reference model reports an empty packet buffer and every expected word has drained, and it flushes any open packet first with delimiter or filler words. Within each configuration, word values are random and biased toward the delimiter, and `out_ready` is randomly withheld so that stalls occur.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic {PF_FILL = 1'b0, PF_DRAIN = 1'b1} pf_state_e;
endpackage

// File: rtl/pf_rst_sync.sv
module pf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pf_term.sv
module pf_term #(
  parameter int DW    = 9,
  parameter int DEPTH = 16,
  parameter int LENW  = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [DW-1:0]   word,
  input  logic [CW-1:0]   cnt_next,
  input  logic [DW:0]     cfg_delim,
  input  logic [LENW-1:0] cfg_len,
  output logic            grp_en,
  output logic            close,
  output logic            forced
);
  localparam int XW = ((CW > LENW) ? CW : LENW) + 1;

  logic delim_on, len_on, delim_hit, len_hit, full;

  always_comb begin
    delim_on  = !cfg_delim[DW];
    len_on    = (cfg_len != '0);
    delim_hit = delim_on && (word == cfg_delim[DW-1:0]);
    len_hit   = len_on && (XW'(cnt_next) == XW'(cfg_len));
    full      = (cnt_next == CW'(DEPTH));
    grp_en    = delim_on || len_on;
    close     = grp_en && (delim_hit || len_hit || full);
    forced    = grp_en && full && !delim_hit && !len_hit;
  end
endmodule

// File: rtl/pf_buf.sv
module pf_buf #(
  parameter int DW    = 9,
  parameter int DEPTH = 16,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] cell_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic cell_we;
    assign cell_we = wr_en && (wr_addr == AW'(i));
    always_ff @(posedge clk) begin
      if (cell_we) cell_q[i] <= wr_data;
    end
  end

  assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TW    = 16,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  input  logic [TW-1:0] time_now,
  input  logic          grp_en,
  input  logic          close,
  input  logic          forced,
  output logic          in_ready,
  output logic          out_valid,
  output logic          out_last,
  output logic          out_ovf,
  output logic [TW-1:0] start_time,
  output logic [TW-1:0] end_time,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] cnt_next
);
  pf_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] rd_q, rd_d, last_q, last_d;
  logic [TW-1:0] st_q, st_d, en_q, en_d;
  logic          ovf_q, ovf_d;
  logic          accept, state_en;

  assign in_ready  = (state_q == PF_FILL);
  assign out_valid = (state_q == PF_DRAIN);
  assign out_last  = out_valid && (rd_q == last_q);
  assign out_ovf   = ovf_q;
  assign start_time = st_q;
  assign end_time  = en_q;
  assign rd_addr   = rd_q;
  assign wr_addr   = cnt_q[AW-1:0];
  assign cnt_next  = cnt_q + CW'(1);
  assign accept    = in_valid && in_ready;
  assign wr_en     = accept && grp_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rd_d    = rd_q;
    last_d  = last_q;
    st_d    = st_q;
    en_d    = en_q;
    ovf_d   = ovf_q;
    if (state_q == PF_FILL) begin
      if (wr_en) begin
        if (cnt_q == '0) st_d = time_now;
        if (close) begin
          state_d = PF_DRAIN;
          last_d  = cnt_q[AW-1:0];
          en_d    = time_now;
          ovf_d   = forced;
          rd_d    = '0;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_next;
        end
      end
    end else if (out_ready) begin
      if (rd_q == last_q) state_d = PF_FILL;
      else                rd_d    = rd_q + AW'(1);
    end
  end

  assign state_en = wr_en || (out_valid && out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PF_FILL;
      cnt_q   <= '0;
      rd_q    <= '0;
      last_q  <= '0;
      st_q    <= '0;
      en_q    <= '0;
      ovf_q   <= 1'b0;
    end else if (state_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
      last_q  <= last_d;
      st_q    <= st_d;
      en_q    <= en_d;
      ovf_q   <= ovf_d;
    end
  end

  // R8: the fill count wraps back to zero on close and never reaches DEPTH
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(DEPTH));

  // R8: a force-closed packet always holds exactly DEPTH words
  assert_ovf_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && out_ovf) |-> (rd_q == AW'(DEPTH - 1)));

  // R10: the final handshake returns the framer to accepting input
  assert_last_reopens_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int DW    = 9,
  parameter int DEPTH = 16,
  parameter int TW    = 16,
  parameter int LENW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_data,
  input  logic [TW-1:0]   time_now,
  input  logic [DW:0]     cfg_delim,
  input  logic [LENW-1:0] cfg_len,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_data,
  output logic            out_last,
  output logic            out_ovf,
  output logic [TW-1:0]   out_start_time,
  output logic [TW-1:0]   out_end_time
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          rst_n_s;
  logic          grp_en, close, forced, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] cnt_next;

  pf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  pf_term #(.DW(DW), .DEPTH(DEPTH), .LENW(LENW), .CW(CW)) u_term (
    .word(in_data), .cnt_next(cnt_next), .cfg_delim(cfg_delim),
    .cfg_len(cfg_len), .grp_en(grp_en), .close(close), .forced(forced)
  );

  pf_buf #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
    .rd_addr(rd_addr), .rd_data(out_data)
  );

  pf_ctrl #(.DEPTH(DEPTH), .TW(TW), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .out_ready(out_ready),
    .time_now(time_now), .grp_en(grp_en), .close(close), .forced(forced),
    .in_ready(in_ready), .out_valid(out_valid), .out_last(out_last),
    .out_ovf(out_ovf), .start_time(out_start_time), .end_time(out_end_time),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .cnt_next(cnt_next)
  );

  // R9: a stalled output word holds until taken
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_last) && $stable(out_start_time)));

  // R2: an accepted closing word leads to a draining packet on the next cycle
  assert_close_drains_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && in_ready && close) |=> (out_valid && !in_ready));

  // R5: with both conditions off, no packet output can start
  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!grp_en && !out_valid) |=> !out_valid);
endmodule

// File: tb/tb_pkt_framer.sv
module tb_pkt_framer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 9, DEPTH = 16, TW = 16, LENW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [TW-1:0] cyc = '0;
  logic [DW:0] cfg_delim = {1'b1, {DW{1'b0}}};
  logic [LENW-1:0] cfg_len = '0;
  logic in_ready, out_valid, out_last, out_ovf;
  logic [DW-1:0] out_data;
  logic [TW-1:0] out_start_time, out_end_time;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  logic [DW-1:0] cur_w[$];
  logic [TW-1:0] cur_st;
  logic [DW-1:0] e_data[$];
  bit            e_last[$], e_ovf[$];
  logic [TW-1:0] e_st[$], e_en[$];

  bit prev_stall = 0;
  logic [DW-1:0] prev_data;
  bit prev_last;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1'b1;

  pkt_framer #(.DW(DW), .DEPTH(DEPTH), .TW(TW), .LENW(LENW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .time_now(cyc), .cfg_delim(cfg_delim), .cfg_len(cfg_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_ovf(out_ovf), .out_start_time(out_start_time),
    .out_end_time(out_end_time)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void model_accept(input logic [DW-1:0] w, input logic [TW-1:0] t);
    bit d_on, l_on, dh, lh, full;
    d_on = !cfg_delim[DW];
    l_on = (cfg_len != 0);
    if (!d_on && !l_on) return;
    if (cur_w.size() == 0) cur_st = t;
    cur_w.push_back(w);
    dh = d_on && (w == cfg_delim[DW-1:0]);
    lh = l_on && (cur_w.size() == int'(cfg_len));
    full = (cur_w.size() == DEPTH);
    if (dh || lh || full) begin
      for (int i = 0; i < cur_w.size(); i++) begin
        e_data.push_back(cur_w[i]);
        e_last.push_back(i == cur_w.size() - 1);
        e_st.push_back(cur_st);
        e_en.push_back(t);
        e_ovf.push_back(full && !dh && !lh);
      end
      cur_w.delete();
    end
  endfunction

  // called at a negedge; returns at a negedge after the word is taken
  task automatic send(input logic [DW-1:0] w);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    model_accept(w, cyc);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (e_data.size() != 0 || out_valid) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_stall) begin
        check(out_valid && out_data == prev_data && out_last == prev_last,
              "R9 stall hold", int'(out_data), int'(prev_data));
      end
      if (out_valid) check(!in_ready, "R10 in_ready while draining", int'(in_ready), 0);
      out_ready = ($urandom % 4) != 0;
      if (out_valid && out_ready) begin
        if (e_data.size() == 0) begin
          check(1'b0, "unexpected word (R5)", int'(out_data), -1);
        end else begin
          check(out_data == e_data[0], "data", int'(out_data), int'(e_data[0]));
          check(out_last == e_last[0], "R9 last", int'(out_last), int'(e_last[0]));
          check(out_start_time == e_st[0], "R7 start time", int'(out_start_time), int'(e_st[0]));
          check(out_end_time == e_en[0], "R7 end time", int'(out_end_time), int'(e_en[0]));
          check(out_ovf == e_ovf[0], "R8 ovf", int'(out_ovf), int'(e_ovf[0]));
          void'(e_data.pop_front()); void'(e_last.pop_front());
          void'(e_st.pop_front()); void'(e_en.pop_front()); void'(e_ovf.pop_front());
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tag = "R1";
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R2: delimiter closes and is kept
    tag = "R2"; cfg_delim = {1'b0, 9'h00A}; cfg_len = 0;
    send(9'h003); send(9'h005); send(9'h00A); drain();
    send(9'h1FF); send(9'h00A); drain();
    // R2: full-width delimiter value
    cfg_delim = {1'b0, 9'h1FF};
    send(9'h011); send(9'h1FF); drain();

    // R3: length only
    tag = "R3"; cfg_delim = {1'b1, 9'h00A}; cfg_len = 4;
    for (int i = 0; i < 8; i++) send(9'(i + 1));
    drain();
    cfg_len = 1; send(9'h077); send(9'h078); drain();

    // R4: whichever first
    tag = "R4"; cfg_delim = {1'b0, 9'h055}; cfg_len = 5;
    send(9'h001); send(9'h055); drain();
    cfg_len = 3; send(9'h001); send(9'h002); send(9'h003); send(9'h055); drain();

    // R6: disabled delimiter ignores matching low bits
    tag = "R6"; cfg_delim = {1'b1, 9'h033}; cfg_len = 6;
    for (int i = 0; i < 6; i++) send(9'h033);
    drain();

    // R8: force close on full buffer, and no flag when length equals DEPTH
    tag = "R8"; cfg_delim = {1'b0, 9'h100}; cfg_len = 0;
    for (int i = 0; i < DEPTH; i++) send(9'(i));
    drain();
    cfg_len = LENW'(DEPTH);
    for (int i = 0; i < DEPTH; i++) send(9'(i + 2));
    drain();
    cfg_len = 0;
    for (int i = 0; i < DEPTH - 1; i++) send(9'(i + 2));
    send(9'h100); drain();

    // R5: both disabled, nothing comes out
    tag = "R5"; cfg_delim = {1'b1, 9'h000}; cfg_len = 0;
    for (int i = 0; i < 10; i++) send(9'(i));
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R5 no output when disabled", int'(out_valid), 0);
    check(e_data.size() == 0, "R5 model empty", e_data.size(), 0);

    // R7/R10: random epochs with gaps and stalls
    tag = "R7";
    for (int ep = 0; ep < 30; ep++) begin
      logic [DW-1:0] dv;
      dv = 9'($urandom);
      cfg_delim = {($urandom % 4) == 0, dv};
      case ($urandom % 4)
        0: cfg_len = 0;
        1: cfg_len = LENW'(1 + $urandom % 4);
        2: cfg_len = LENW'(1 + $urandom % 20);
        default: cfg_len = LENW'(DEPTH);
      endcase
      tag = (ep % 2 == 0) ? "R7" : "R10";
      for (int i = 0; i < 40; i++) begin
        if (($urandom % 6) == 0) send(dv);
        else send(9'($urandom));
        if (($urandom % 5) == 0) repeat ($urandom % 3 + 1) @(negedge clk);
      end
      while (cur_w.size() != 0) send(cfg_delim[DW] ? 9'($urandom) : dv);
      drain();
    end

    repeat (4) @(negedge clk);
    tag = "R10";
    check(e_data.size() == 0, "R10 all packets delivered", e_data.size(), 0);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R10 idle at end",
          int'({in_ready, out_valid}), 2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule